// File: doc/BRIEF.md
# Banked Working-Register Window

This block is a small on-chip data RAM. Its lowest 32 bytes double as a file of working registers, split into four banks of eight bytes each. A core names one of its eight working registers with a 3-bit register number. A 2-bit bank field, kept in an 8-bit status register, picks which group of eight bytes that number reaches. The physical byte is the bank field times eight plus the register number.

The RAM has a second, direct byte port. Any location can be read or written through it by its plain address, including every byte that also serves as a working register. A value written through either port can be read through the other. Both read ports are combinational. Writes land on the rising clock edge. The status register has its own write port. All eight of its bits are held and read back, but only bits 4:3 choose the bank.

Top module: `regwin_top`

## Requirements
- R1: After reset the status register reads 00h, so register numbers reach bank 0 (bytes 00h to 07h).
- R2: A status write stores all eight bits, and the value is read back in the next cycle.
- R3: A register-number access reaches byte address `status[4:3]*8 + idx`. So bank 0 covers 00h-07h, bank 1 08h-0Fh, bank 2 10h-17h and bank 3 18h-1Fh.
- R4: A byte written through the register port is returned by a register-port read of the same number, with the same bank, in the next cycle.
- R5: A byte written through the direct port at any address from 0 to DEPTH-1 is returned by a direct read of that address in the next cycle. This includes addresses above 1Fh.
- R6: The two ports alias the same bytes. A direct write inside the active bank shows on the matching register-number read. A register-port write shows on the matching direct read.
- R7: A new bank select applies from the cycle after the status write. In the write cycle itself, register reads still use the old bank.
- R8: When both ports write the same byte in the same cycle, the direct port's data is stored.
- R9: Status bits 7:5 and 2:0 have no effect on which byte a register number reaches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_we | input | 1 | Register-port write enable |
| rn_idx | input | 3 | Register number R0 to R7 |
| rn_wdata | input | 8 | Register-port write data |
| rn_rdata | output | 8 | Register-port read data (combinational) |
| da_we | input | 1 | Direct-port write enable |
| da_addr | input | 6 | Direct byte address |
| da_wdata | input | 8 | Direct-port write data |
| da_rdata | output | 8 | Direct-port read data (combinational) |
| st_we | input | 1 | Status register write enable |
| st_wdata | input | 8 | Status register write data |
| st_rdata | output | 8 | Current status register value |

## Verification
The readback properties assume the cycle after a write reads the location that was written. When the address moves on, or a status write has just re-banked the register port, the property excuses the check. The aliasing property also assumes the direct port did not write in the same cycle.

The stimulus keeps to one write port at a time, except in the deliberate same-byte collision. Every value is written before it is read, so no property compares against storage that was never written. Because the storage has no reset, the bench never reads a byte it has not written.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_BANKS = 4;
  localparam int BANK_REGS = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int IDX_W     = $clog2(BANK_REGS);
  localparam int SEL_LSB   = 3;   // bank field sits at status[4:3]
  localparam int WIN_BYTES = NUM_BANKS * BANK_REGS;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/regwin_status.sv
module regwin_status
  import regwin_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  byte_t               wr_data,
  output byte_t               stat_q,
  output logic [BANK_W-1:0]   bank_sel
);
  byte_t stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en) stat_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign bank_sel = stat_q[SEL_LSB +: BANK_W];
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  output logic [ADDR_W-1:0] phys_addr
);
  // bank * BANK_REGS + idx, as a concatenation since BANK_REGS is a power of two
  assign phys_addr = ADDR_W'({bank_sel, reg_idx});
endmodule

// File: rtl/regwin_store.sv
module regwin_store
  import regwin_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              pa_we,     // priority port (direct)
  input  logic [ADDR_W-1:0] pa_addr,
  input  byte_t             pa_wdata,
  output byte_t             pa_rdata,
  input  logic              pb_we,     // secondary port (register number)
  input  logic [ADDR_W-1:0] pb_addr,
  input  byte_t             pb_wdata,
  output byte_t             pb_rdata
);
  byte_t             cells   [DEPTH];
  byte_t             cell_d  [DEPTH];
  logic [DEPTH-1:0]  cell_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic hit_a, hit_b;
    assign hit_a      = pa_we && (pa_addr == ADDR_W'(g));
    assign hit_b      = pb_we && (pb_addr == ADDR_W'(g));
    assign cell_en[g] = hit_a || hit_b;
    assign cell_d[g]  = hit_a ? pa_wdata : pb_wdata;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (cell_en[i]) cells[i] <= cell_d[i];
    end
  end

  assign pa_rdata = cells[pa_addr];
  assign pb_rdata = cells[pb_addr];
endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rn_we,
  input  logic [2:0]        rn_idx,
  input  logic [7:0]        rn_wdata,
  output logic [7:0]        rn_rdata,
  input  logic              da_we,
  input  logic [ADDR_W-1:0] da_addr,
  input  logic [7:0]        da_wdata,
  output logic [7:0]        da_rdata,
  input  logic              st_we,
  input  logic [7:0]        st_wdata,
  output logic [7:0]        st_rdata
);
  logic [BANK_W-1:0] bank_sel;
  logic [ADDR_W-1:0] rn_phys;

  regwin_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_we),
    .wr_data  (st_wdata),
    .stat_q   (st_rdata),
    .bank_sel (bank_sel)
  );

  regwin_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .bank_sel  (bank_sel),
    .reg_idx   (rn_idx),
    .phys_addr (rn_phys)
  );

  regwin_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .pa_we    (da_we),
    .pa_addr  (da_addr),
    .pa_wdata (da_wdata),
    .pa_rdata (da_rdata),
    .pb_we    (rn_we),
    .pb_addr  (rn_phys),
    .pb_wdata (rn_wdata),
    .pb_rdata (rn_rdata)
  );
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rn_we,
  input logic [2:0]        rn_idx,
  input logic [7:0]        rn_wdata,
  input logic [7:0]        rn_rdata,
  input logic              da_we,
  input logic [ADDR_W-1:0] da_addr,
  input logic [7:0]        da_wdata,
  input logic [7:0]        da_rdata,
  input logic              st_we,
  input logic [7:0]        st_wdata,
  input logic [7:0]        st_rdata
);
  p_reset_bank0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> st_rdata == 8'h00);

  p_status_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> st_rdata == $past(st_wdata));

  p_status_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> $stable(st_rdata));

  p_rn_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_we && !da_we && !st_we) |=>
      (rn_idx != $past(rn_idx)) || (rn_rdata == $past(rn_wdata)));

  // R8 is covered as well: the direct port's data must survive a collision.
  p_da_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    da_we |=> (da_addr != $past(da_addr)) || (da_rdata == $past(da_wdata)));

  p_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_we && !da_we && !st_we) |=>
      (da_addr != ADDR_W'({$past(st_rdata[4:3]), $past(rn_idx)})) ||
      (da_rdata == $past(rn_wdata)));
endmodule

bind regwin_top regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rn_we(rn_we), .rn_idx(rn_idx), .rn_wdata(rn_wdata), .rn_rdata(rn_rdata),
  .da_we(da_we), .da_addr(da_addr), .da_wdata(da_wdata), .da_rdata(da_rdata),
  .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata)
);

// File: tb/regwin_top_bench.sv
`timescale 1ns/1ps
module regwin_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rn_we, da_we, st_we;
  logic [2:0] rn_idx;
  logic [5:0] da_addr;
  logic [7:0] rn_wdata, da_wdata, st_wdata;
  logic [7:0] rn_rdata, da_rdata, st_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regwin_top u_regwin_top (
    .clk(clk), .rst_n(rst_n),
    .rn_we(rn_we), .rn_idx(rn_idx), .rn_wdata(rn_wdata), .rn_rdata(rn_rdata),
    .da_we(da_we), .da_addr(da_addr), .da_wdata(da_wdata), .da_rdata(da_rdata),
    .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  // {status, reg number, data, expected direct address}; bank = status[4:3]
  localparam logic [24:0] VEC [8] = '{
    {8'h00, 3'd0, 8'hA1, 6'h00},
    {8'h08, 3'd1, 8'hB2, 6'h09},
    {8'h10, 3'd7, 8'hC3, 6'h17},
    {8'h18, 3'd5, 8'hD4, 6'h1D},
    {8'hE7, 3'd3, 8'h5A, 6'h03},   // R9: only 7:5 and 2:0 set
    {8'hFF, 3'd7, 8'h6B, 6'h1F},
    {8'h0C, 3'd2, 8'h7C, 6'h0A},   // R9: bit 2 set, bank 1
    {8'h97, 3'd6, 8'h8D, 6'h16}    // R9: bank 2 with noise bits
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic st_write(input logic [7:0] v);
    st_we = 1'b1; st_wdata = v; tick(); st_we = 1'b0;
  endtask

  task automatic rn_write(input logic [2:0] i, input logic [7:0] d);
    rn_we = 1'b1; rn_idx = i; rn_wdata = d; tick(); rn_we = 1'b0;
  endtask

  task automatic da_write(input logic [5:0] a, input logic [7:0] d);
    da_we = 1'b1; da_addr = a; da_wdata = d; tick(); da_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rn_we = 0; da_we = 0; st_we = 0;
    rn_idx = '0; da_addr = '0; rn_wdata = '0; da_wdata = '0; st_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R1 reset status", st_rdata, 8'h00);

    // R1: bank 0 reached after reset
    rn_write(3'd2, 8'h3C);
    da_addr = 6'h02; #1;
    chk("R1 bank0 after reset", da_rdata, 8'h3C);

    // Table walk: R3 mapping, R6 alias, R9 ignored bits
    for (int k = 0; k < 8; k++) begin
      logic [24:0] v;
      v = VEC[k];
      st_write(v[24:17]);
      chk("R2 status readback", st_rdata, v[24:17]);
      rn_write(v[16:14], v[13:6]);
      da_addr = v[5:0]; rn_idx = v[16:14]; #1;
      chk("R3 R6 R9 reg-to-direct", da_rdata, v[13:6]);
      chk("R4 reg readback", rn_rdata, v[13:6]);
    end

    // R6 reverse: direct write inside bank 3, read via register number
    st_write(8'h18);
    da_write(6'h1A, 8'h4E);
    rn_idx = 3'd2; #1;
    chk("R6 direct-to-reg", rn_rdata, 8'h4E);

    // R5: direct byte above the window
    da_write(6'h3F, 8'h99);
    da_addr = 6'h3F; #1;
    chk("R5 upper byte", da_rdata, 8'h99);
    da_write(6'h20, 8'h12);
    da_addr = 6'h20; #1;
    chk("R5 byte 20h", da_rdata, 8'h12);

    // R7: bank switch timing
    st_write(8'h00);
    da_write(6'h04, 8'h11);
    da_write(6'h14, 8'h22);
    st_we = 1'b1; st_wdata = 8'h10; rn_idx = 3'd4; #1;
    chk("R7 old bank during write", rn_rdata, 8'h11);
    tick(); st_we = 1'b0; #1;
    chk("R7 new bank after write", rn_rdata, 8'h22);

    // R8: same-byte collision, direct wins
    st_write(8'h08);
    rn_we = 1'b1; rn_idx = 3'd3; rn_wdata = 8'hAA;
    da_we = 1'b1; da_addr = 6'h0B; da_wdata = 8'h55;
    tick(); rn_we = 1'b0; da_we = 1'b0; #1;
    chk("R8 collision direct view", da_rdata, 8'h55);
    chk("R8 collision reg view", rn_rdata, 8'h55);

    // R9: noise bits leave bank 1 mapping intact
    st_write(8'hEF);   // bit4=0, bit3=1
    rn_idx = 3'd3; #1;
    chk("R9 noise bits", rn_rdata, 8'h55);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule